// File: doc/BRIEF.md
# Privilege-Gated Event Counter Bank

This block holds a small bank of wide event counters, two by default and 40 bits each. Every counter advances by one on its own event strobe. User-level code reads the counters through a request/response port with valid/ready handshakes. A read request carries a 32-bit counter index, the current privilege level and an enable bit taken from an outside control register. The response returns the selected count split over two 32-bit words, or it flags a fault and returns zeros.

A second port serves privileged software. At privilege level 0 it can load any counter with a full 40-bit value or read it back whole. An access from any other level, or one that names a counter that does not exist, changes nothing and raises a fault pulse.

The user read does not wait for in-flight events to settle. It returns the count present at the clock edge that accepts the request. The read request handshake completes when `rd_valid` and `rd_ready` are both high at a rising edge. `rd_ready` is high whenever the response register is empty or is being drained in that same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and no new request is taken.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter is zero, `rsp_valid`, `pa_rvalid` and `pa_fault` are low, and `rd_ready` is high.
- R2: A counter whose event strobe is high at a rising edge, with no privileged load to it in that cycle, grows by exactly one. A counter that is all ones goes to zero. A counter with neither a strobe nor a load keeps its value.
- R3: The whole 32-bit read index is compared. Only the values 0 and 1 pick a counter. Any other value, including ones that differ only in high bits, gives `rsp_fault`=1 with both result words zero.
- R4: A read at privilege level 0 is always allowed. A read at levels 1, 2 or 3 is allowed only when `rd_user_en`=1. Otherwise it faults with zero result words.
- R5: An allowed read returns count bits 39:32 in `rsp_hi[7:0]` and bits 31:0 in `rsp_lo`. `rsp_hi[31:8]` is always zero.
- R6: The response becomes valid on the rising edge that accepts the request. It carries the count as it stood just before that edge, so an event in the same cycle is not included.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, the response words and fault stay unchanged and `rd_ready`=0. The response clears on the first edge with `rsp_ready`=1 when no new request is accepted.
- R8: A privileged write (`pa_en`=1, `pa_we`=1, level 0, index 0 or 1) loads all 40 bits of `pa_wdata` into that counter. It takes priority over that counter's event strobe in the same cycle.
- R9: A privileged read at level 0 of index 0 or 1 puts the full 40-bit count on `pa_rdata`, with `pa_rvalid`=1, one cycle later.
- R10: A privileged access at a non-zero level or with an index other than 0 or 1 loads nothing. It gives `pa_fault`=1 for exactly one cycle, with `pa_rvalid`=0 and `pa_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | NUM_CNT | One event pulse per counter |
| rd_valid | input | 1 | User read request present |
| rd_ready | output | 1 | User read request can be accepted |
| rd_index | input | 32 | Counter index of the user read |
| rd_lvl | input | 2 | Privilege level of the requester |
| rd_user_en | input | 1 | Permits reads from levels 1 to 3 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hi | output | 32 | Upper count bits, zero-extended |
| rsp_lo | output | 32 | Lower 32 count bits |
| rsp_fault | output | 1 | Read refused; result words are zero |
| pa_en | input | 1 | Privileged access strobe |
| pa_we | input | 1 | 1 = load, 0 = read |
| pa_lvl | input | 2 | Privilege level of the privileged access |
| pa_index | input | 32 | Counter index of the privileged access |
| pa_wdata | input | CNT_W | Load value |
| pa_rvalid | output | 1 | Privileged read data valid |
| pa_rdata | output | CNT_W | Privileged read data |
| pa_fault | output | 1 | Privileged access refused |

## Verification
The hardest situation to reach is a stalled response that must stay frozen while counters keep moving and a second request waits at the input. The bench holds `rsp_ready` low after an accepted read and then pulses the event strobe of the counter just read for several cycles. It keeps a request for the other counter asserted throughout, then releases the stall and checks that only the original count left the block. The carry from bit 31 into the high word and the wrap at all ones depend on values far from reset. The bench reaches them by preloading counters through the privileged port, in the same cycle as an event where priority is under test.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LVL_W  = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // Privilege rule shared by the read paths: ring 0 always, others only when opened up.
  function automatic logic lvl_allows(input lvl_t lvl, input logic open_en);
    return (lvl == '0) || open_en;
  endfunction
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (inc)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evc_sel.sv
module evc_sel #(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned IDX_W   = 32
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [NUM_CNT-1:0]       onehot,
  output logic                     hit,
  output logic [CNT_W-1:0]         value
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cmp
    assign onehot[g] = (idx == IDX_W'(g));
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (onehot[i]) value = value | cnt_flat[i*CNT_W +: CNT_W];
    end
  end

  assign hit = |onehot;
endmodule

// File: rtl/evc_user_rd.sv
module evc_user_rd
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned IDX_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_valid,
  output logic                     rd_ready,
  input  logic [IDX_W-1:0]         rd_index,
  input  lvl_t                     rd_lvl,
  input  logic                     rd_user_en,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [WORD_W-1:0]        rsp_hi,
  output logic [WORD_W-1:0]        rsp_lo,
  output logic                     rsp_fault
);
  logic [NUM_CNT-1:0] sel_oh;
  logic               sel_hit;
  logic [CNT_W-1:0]   sel_val;
  logic               take, granted;
  logic               v_q, f_q;
  logic [WORD_W-1:0]  hi_q, lo_q;

  evc_sel #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sel (
    .idx(rd_index), .cnt_flat(cnt_flat),
    .onehot(sel_oh), .hit(sel_hit), .value(sel_val)
  );

  assign rd_ready = !v_q || rsp_ready;
  assign take     = rd_valid && rd_ready;
  assign granted  = sel_hit && lvl_allows(rd_lvl, rd_user_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      f_q  <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (take) begin
      v_q  <= 1'b1;
      f_q  <= !granted;
      hi_q <= granted ? WORD_W'(sel_val >> WORD_W) : '0;
      lo_q <= granted ? sel_val[WORD_W-1:0] : '0;
    end else if (rsp_ready) begin
      v_q  <= 1'b0;
      f_q  <= 1'b0;
    end
  end

  assign rsp_valid = v_q;
  assign rsp_fault = f_q;
  assign rsp_hi    = hi_q;
  assign rsp_lo    = lo_q;
endmodule

// File: rtl/evc_priv.sv
module evc_priv
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned IDX_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pa_en,
  input  logic                     pa_we,
  input  lvl_t                     pa_lvl,
  input  logic [IDX_W-1:0]         pa_index,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [NUM_CNT-1:0]       wr_hit,
  output logic                     pa_rvalid,
  output logic [CNT_W-1:0]         pa_rdata,
  output logic                     pa_fault
);
  logic [NUM_CNT-1:0] sel_oh;
  logic               sel_hit;
  logic [CNT_W-1:0]   sel_val;
  logic               legal, rd_go;
  logic               rv_q, flt_q;
  logic [CNT_W-1:0]   rd_q;

  evc_sel #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sel (
    .idx(pa_index), .cnt_flat(cnt_flat),
    .onehot(sel_oh), .hit(sel_hit), .value(sel_val)
  );

  // Only ring 0 may use this port; the user enable plays no part here.
  assign legal  = sel_hit && lvl_allows(pa_lvl, 1'b0);
  assign rd_go  = pa_en && !pa_we && legal;
  assign wr_hit = sel_oh & {NUM_CNT{pa_en && pa_we && legal}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      flt_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rv_q  <= rd_go;
      flt_q <= pa_en && !legal;
      rd_q  <= rd_go ? sel_val : '0;
    end
  end

  assign pa_rvalid = rv_q;
  assign pa_fault  = flt_q;
  assign pa_rdata  = rd_q;
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned IDX_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CNT-1:0]   ev_strobe,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [IDX_W-1:0]     rd_index,
  input  logic [LVL_W-1:0]     rd_lvl,
  input  logic                 rd_user_en,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_hi,
  output logic [WORD_W-1:0]    rsp_lo,
  output logic                 rsp_fault,
  input  logic                 pa_en,
  input  logic                 pa_we,
  input  logic [LVL_W-1:0]     pa_lvl,
  input  logic [IDX_W-1:0]     pa_index,
  input  logic [CNT_W-1:0]     pa_wdata,
  output logic                 pa_rvalid,
  output logic [CNT_W-1:0]     pa_rdata,
  output logic                 pa_fault
);
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       wr_hit;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(ev_strobe[g]), .ld(wr_hit[g]), .ld_val(pa_wdata),
      .cnt(cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  evc_user_rd #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_urd (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_index(rd_index),
    .rd_lvl(rd_lvl), .rd_user_en(rd_user_en), .cnt_flat(cnt_flat),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .rsp_fault(rsp_fault)
  );

  evc_priv #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_priv (
    .clk(clk), .rst_n(rst_n),
    .pa_en(pa_en), .pa_we(pa_we), .pa_lvl(pa_lvl), .pa_index(pa_index),
    .cnt_flat(cnt_flat), .wr_hit(wr_hit),
    .pa_rvalid(pa_rvalid), .pa_rdata(pa_rdata), .pa_fault(pa_fault)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 40
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CNT-1:0]       ev_strobe,
  input logic [NUM_CNT-1:0]       wr_hit,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [CNT_W-1:0]         pa_wdata,
  input logic                     pa_en,
  input logic [LVL_W-1:0]         pa_lvl,
  input logic                     rd_valid,
  input logic                     rd_ready,
  input logic [LVL_W-1:0]         rd_lvl,
  input logic                     rd_user_en,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [WORD_W-1:0]        rsp_hi,
  input logic [WORD_W-1:0]        rsp_lo,
  input logic                     rsp_fault
);
  a_r5_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_hi >> (CNT_W - WORD_W)) == '0));

  a_r3_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_hi == '0 && rsp_lo == '0));

  a_r4_gate_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_lvl != '0 && !rd_user_en) |=> (rsp_valid && rsp_fault));

  a_r6_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hi) && $stable(rsp_lo) && $stable(rsp_fault)));

  a_r10_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en && pa_lvl != '0) |-> (wr_hit == '0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_c
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> (cnt_flat[g*CNT_W +: CNT_W] == $past(pa_wdata)));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_strobe[g] && !wr_hit[g]) |=>
        (cnt_flat[g*CNT_W +: CNT_W] == CNT_W'($past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_strobe[g] && !wr_hit[g]) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
  end
endmodule

bind evc_bank evc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .wr_hit(wr_hit),
  .cnt_flat(cnt_flat), .pa_wdata(pa_wdata), .pa_en(pa_en), .pa_lvl(pa_lvl),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_lvl(rd_lvl),
  .rd_user_en(rd_user_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .rsp_fault(rsp_fault)
);

// File: tb/test_evc_bank.sv
`timescale 1ns/1ps
module test_evc_bank;
  localparam int unsigned NC = 2;
  localparam int unsigned CW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] ev = '0;
  logic          rd_valid = 1'b0, rd_ready;
  logic [31:0]   rd_index = '0;
  logic [1:0]    rd_lvl = '0;
  logic          rd_user_en = 1'b0;
  logic          rsp_valid, rsp_ready = 1'b1, rsp_fault;
  logic [31:0]   rsp_hi, rsp_lo;
  logic          pa_en = 1'b0, pa_we = 1'b0;
  logic [1:0]    pa_lvl = '0;
  logic [31:0]   pa_index = '0;
  logic [CW-1:0] pa_wdata = '0;
  logic          pa_rvalid, pa_fault;
  logic [CW-1:0] pa_rdata;

  logic [CW-1:0] mdl [NC];
  int unsigned   n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  evc_bank i_evc_bank (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_index(rd_index),
    .rd_lvl(rd_lvl), .rd_user_en(rd_user_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .rsp_fault(rsp_fault),
    .pa_en(pa_en), .pa_we(pa_we), .pa_lvl(pa_lvl), .pa_index(pa_index),
    .pa_wdata(pa_wdata), .pa_rvalid(pa_rvalid), .pa_rdata(pa_rdata),
    .pa_fault(pa_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs were set at the falling edge; model follows the requirements.
  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin
      if (rst_n && pa_en && pa_we && pa_lvl == 2'd0 && pa_index == 32'(i)) mdl[i] = pa_wdata;
      else if (rst_n && ev[i]) mdl[i] = mdl[i] + 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [31:0] idx, input logic [CW-1:0] val, input logic [1:0] lvl);
    pa_en = 1'b1; pa_we = 1'b1; pa_index = idx; pa_wdata = val; pa_lvl = lvl;
    tick();
    pa_en = 1'b0; pa_we = 1'b0;
  endtask

  task automatic pread(input logic [31:0] idx, input logic [1:0] lvl, input string tag);
    logic ok;
    logic [CW-1:0] exp;
    ok  = (idx < 32'(NC)) && (lvl == 2'd0);
    exp = ok ? mdl[idx[0]] : '0;
    pa_en = 1'b1; pa_we = 1'b0; pa_index = idx; pa_lvl = lvl;
    tick();
    pa_en = 1'b0;
    chk({tag, " pa_rvalid"}, 64'(pa_rvalid), 64'(ok));
    chk({tag, " pa_fault"}, 64'(pa_fault), 64'(!ok));
    chk({tag, " pa_rdata"}, 64'(pa_rdata), 64'(exp));
  endtask

  task automatic uread(input logic [31:0] idx, input logic [1:0] lvl, input logic en, input string tag);
    logic ok;
    logic [CW-1:0] v;
    ok = (idx < 32'(NC)) && (lvl == 2'd0 || en);
    v  = ok ? mdl[idx[0]] : '0;
    rd_valid = 1'b1; rd_index = idx; rd_lvl = lvl; rd_user_en = en;
    tick();
    rd_valid = 1'b0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rsp_fault"}, 64'(rsp_fault), 64'(!ok));
    chk({tag, " rsp_hi"}, 64'(rsp_hi), {56'd0, v[39:32]});
    chk({tag, " rsp_lo"}, 64'(rsp_lo), {32'd0, v[31:0]});
  endtask

  initial begin
    logic [31:0] idx_set [7];
    logic [CW-1:0] held;
    idx_set = '{32'd0, 32'd1, 32'd2, 32'd3, 32'h0001_0000, 32'hFFFF_FFFF, 32'h8000_0001};
    for (int i = 0; i < NC; i++) mdl[i] = '0;

    @(negedge clk);
    tick(); tick();
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 pa_rvalid", 64'(pa_rvalid), 0);
    chk("R1 pa_fault", 64'(pa_fault), 0);
    chk("R1 rd_ready", 64'(rd_ready), 1);
    pread(32'd0, 2'd0, "R1 cnt0 zero");
    pread(32'd1, 2'd0, "R1 cnt1 zero");

    // R2 counting on separate and joint strobes
    for (int k = 0; k < 9; k++) begin
      ev = 2'(k % 3 + 1);
      tick();
    end
    ev = '0;
    uread(32'd0, 2'd0, 1'b0, "R2 cnt0 after strobes");
    uread(32'd1, 2'd0, 1'b0, "R2 cnt1 after strobes");

    // R2 wrap at all ones; R5 carry into the high word
    pwrite(32'd0, 40'hFF_FFFF_FFFF, 2'd0);
    ev = 2'b01; tick(); ev = '0;
    pread(32'd0, 2'd0, "R2 wrap to zero");
    pwrite(32'd1, 40'h00_FFFF_FFFF, 2'd0);
    ev = 2'b10; tick(); ev = '0;
    uread(32'd1, 2'd3, 1'b1, "R5 carry into hi");

    // R8 load wins over a same-cycle event
    ev = 2'b11;
    pwrite(32'd0, 40'h12_3456_789A, 2'd0);
    ev = '0;
    pread(32'd0, 2'd0, "R8 load beats strobe");
    pread(32'd1, 2'd0, "R8 other counter still counts");

    // R9 full-width privileged read
    pwrite(32'd1, 40'hC3_0F0F_F0F0, 2'd0);
    pread(32'd1, 2'd0, "R9 priv read");

    // R10 refused privileged accesses
    pwrite(32'd0, 40'h00_0000_0001, 2'd2);
    chk("R10 fault pulse lvl2 write", 64'(pa_fault), 1);
    tick();
    chk("R10 fault one cycle", 64'(pa_fault), 0);
    pread(32'd0, 2'd0, "R10 no load from lvl2");
    pwrite(32'h0000_0002, 40'h55, 2'd0);
    chk("R10 fault bad index", 64'(pa_fault), 1);
    pread(32'd1, 2'd0, "R10 counters untouched");
    pread(32'h1_0000 , 2'd0, "R10 bad index read");
    pread(32'd1, 2'd1, "R10 lvl1 read");

    // R3 R4 R5 sweep over level, enable and index
    pwrite(32'd0, 40'hA5_1234_5678, 2'd0);
    pwrite(32'd1, 40'h3C_DEAD_BEEF, 2'd0);
    for (int l = 0; l < 4; l++)
      for (int e = 0; e < 2; e++)
        for (int x = 0; x < 7; x++)
          uread(idx_set[x], 2'(l), 1'(e), "R3 R4 R5 sweep");

    // R6 same-cycle event not included
    ev = 2'b01;
    uread(32'd0, 2'd0, 1'b0, "R6 pre-edge value");
    ev = '0;
    uread(32'd0, 2'd0, 1'b0, "R6 event seen next read");

    // R7 stall: response frozen while counters move and a request waits
    held = mdl[0];
    rsp_ready = 1'b0;
    uread(32'd0, 2'd0, 1'b0, "R7 stalled read");
    chk("R7 rd_ready low", 64'(rd_ready), 0);
    rd_valid = 1'b1; rd_index = 32'd1; ev = 2'b01;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7 held valid", 64'(rsp_valid), 1);
      chk("R7 held lo", 64'(rsp_lo), {32'd0, held[31:0]});
      chk("R7 held hi", 64'(rsp_hi), {56'd0, held[39:32]});
    end
    rd_valid = 1'b0; ev = '0; rsp_ready = 1'b1;
    tick();
    chk("R7 drained", 64'(rsp_valid), 0);
    uread(32'd0, 2'd0, 1'b0, "R7 counting went on");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule